// File: doc/BRIEF.md
# Vital Product Data ROM Access Controller

This block gives a host a register window onto the product-data area of a serial configuration ROM. The host programs a 16-bit control word that holds a product-data byte address and a direction flag, and a 32-bit data word. Each write of the control word while the block is idle starts a fixed four-byte transfer. The block adds a fixed base of 080h to the product-data address to form a 9-bit ROM address. It then moves the four bytes in ascending order, one per handshake, over a byte-wide request/acknowledge port.

The product-data area is 384 bytes long, addresses 000h to 17Fh. Its lower 128 bytes are read-only from this window, and the remaining 256 bytes can be read and written. Reads can start on any byte. A read that runs past the end of the ROM wraps to ROM address 000h, and those wrapped bytes are returned even though they are not product data. During a write, every byte whose ROM address is outside the writable range is skipped. The host polls the flag to learn when a transfer is done. The flag rises when a read finishes and falls when a write finishes.

Top module: `vpd_rom_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, the control readback, the data readback and `rom_req` are all zero.
- R2: The control readback returns the latched byte address in bits 8:0 and the flag in bit 15. All other bits read as 0.
- R3: The first ROM address of a transfer is the latched byte address plus 080h, modulo 512. Each following byte uses the next ROM address up.
- R4: A control write with bit 15 = 0 starts a read. The flag reads 0 while the read runs and reads 1 from the cycle after the last byte's acknowledge.
- R5: When a read finishes, data bits 7:0 hold the byte at the start address, and bits 15:8, 23:16 and 31:24 hold the three bytes that follow it.
- R6: A control write with bit 15 = 1 starts a write. Data bits 8k+7:8k go to ROM address start+080h+k, and the flag reads 0 from the cycle after the transfer finishes.
- R7: A write issues a ROM request only for bytes whose ROM address lies in 100h..1FFh. All other bytes are skipped, one cycle each, and their ROM contents are left unchanged.
- R8: ROM addresses wrap from 1FFh to 000h within one transfer. On a read, the wrapped bytes are fetched and returned.
- R9: `rom_req`, `rom_addr`, `rom_we` and `rom_wdata` hold steady from the rise of `rom_req` until `rom_ack`. Each acknowledge completes exactly one byte.
- R10: A write to the control word or to the data word while a transfer is in progress has no effect.
- R11: A write whose four bytes are all outside the writable range issues no ROM request and still clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ctl_we | input | 1 | Write strobe for the control word |
| host_ctl_wdata | input | 16 | Control word: byte address in 8:0, flag in 15 |
| host_dat_we | input | 1 | Write strobe for the data word |
| host_dat_wdata | input | 32 | Data word to write |
| host_ctl_rdata | output | 16 | Control word readback |
| host_dat_rdata | output | 32 | Data word readback |
| rom_req | output | 1 | Byte request to the ROM |
| rom_we | output | 1 | 1 = byte write, 0 = byte read |
| rom_addr | output | 9 | ROM byte address |
| rom_wdata | output | 8 | Byte to write |
| rom_ack | input | 1 | Byte acknowledge from the ROM |
| rom_rdata | input | 8 | Byte read, valid with `rom_ack` |

## Verification
The bench goes after start addresses near the end of the ROM. A design that got the wrap wrong there would either stop short or request addresses that do not exist, instead of returning ROM bytes 000h onward. It also runs writes that straddle the read-only boundary, whether leading, trailing or fully protected. A design with a wrong protection test would corrupt the read-only area or stall waiting for an acknowledge that never comes. Control and data writes issued mid-transfer would, in a careless design, retarget the transfer or overwrite the returned bytes. The bench also varies the acknowledge latency, which exposes a flag that flips early or a byte captured from the wrong lane.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    // Default geometry of the product-data window
    localparam int VPD_ADDR_W   = 9;
    localparam int ROM_ADDR_W   = 9;
    localparam int XFER_BYTES   = 4;
    localparam int CTL_W        = 16;
    localparam int CTL_FLAG_BIT = 15;
    localparam int ROM_BASE     = 'h080;
    localparam int WR_LO        = 'h100;
    localparam int WR_SIZE      = 'h100;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/vpd_addr_map.sv
module vpd_addr_map #(
    parameter  int VPD_AW   = 9,
    parameter  int ROM_AW   = 9,
    parameter  int NBYTES   = 4,
    parameter  int BASE     = 'h080,
    parameter  int RW_LO    = 'h100,
    parameter  int RW_SIZE  = 'h100,
    localparam int IW       = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic [VPD_AW-1:0] start_addr,
    input  logic [IW-1:0]     lane_idx,
    output logic [ROM_AW-1:0] lane_addr,
    output logic              lane_writable
);

    localparam logic [ROM_AW:0] LO_X = (ROM_AW+1)'(RW_LO);
    localparam logic [ROM_AW:0] HI_X = (ROM_AW+1)'(RW_LO + RW_SIZE);

    logic [ROM_AW-1:0] lane_a [NBYTES];
    logic [NBYTES-1:0] lane_w;

    // One address and one protection decision per byte lane
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        logic [ROM_AW:0] ext;
        assign lane_a[k] = ROM_AW'(start_addr) + ROM_AW'(BASE) + ROM_AW'(k);
        assign ext       = {1'b0, lane_a[k]};
        assign lane_w[k] = (ext >= LO_X) && (ext < HI_X);
    end

    assign lane_addr     = lane_a[lane_idx];
    assign lane_writable = lane_w[lane_idx];

endmodule

// File: rtl/vpd_host_regs.sv
module vpd_host_regs #(
    parameter  int VPD_AW   = 9,
    parameter  int CTL_W    = 16,
    parameter  int FLAG_BIT = 15,
    parameter  int NBYTES   = 4,
    localparam int IW       = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int DW       = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              dat_we,
    input  logic [DW-1:0]     dat_wdata,
    input  logic              busy,
    input  logic              cap_en,
    input  logic [IW-1:0]     cap_idx,
    input  logic [7:0]        cap_byte,
    input  logic              op_done,
    output logic              go,
    output logic              go_write,
    output logic [VPD_AW-1:0] start_addr,
    output logic [DW-1:0]     dat_q,
    output logic [CTL_W-1:0]  ctl_rdata
);

    typedef struct packed {
        logic [VPD_AW-1:0] addr;
        logic              flag;
        logic [DW-1:0]     data;
    } host_regs_t;

    host_regs_t r_d, r_q;

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^ctl_wdata[CTL_W-1:VPD_AW];

    always_comb begin
        r_d      = r_q;
        go       = ctl_we && !busy;
        go_write = ctl_wdata[FLAG_BIT];
        if (go) begin
            r_d.addr = ctl_wdata[VPD_AW-1:0];
            r_d.flag = ctl_wdata[FLAG_BIT];
        end
        if (dat_we && !busy) begin
            r_d.data = dat_wdata;
        end
        if (cap_en) begin
            r_d.data[8*cap_idx +: 8] = cap_byte;
        end
        if (op_done) begin
            r_d.flag = ~r_q.flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctl_rdata                = '0;
        ctl_rdata[VPD_AW-1:0]    = r_q.addr;
        ctl_rdata[FLAG_BIT]      = r_q.flag;
    end

    assign start_addr = r_q.addr;
    assign dat_q      = r_q.data;

endmodule

// File: rtl/vpd_xfer_seq.sv
module vpd_xfer_seq
    import vpd_pkg::*;
#(
    parameter  int ROM_AW = 9,
    parameter  int NBYTES = 4,
    localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
    localparam int DW     = 8 * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_write,
    input  logic [DW-1:0]     wr_data,
    input  logic [ROM_AW-1:0] lane_addr,
    input  logic              lane_writable,
    input  logic              rom_ack,
    input  logic [7:0]        rom_rdata,
    output logic [IW-1:0]     byte_idx,
    output logic              busy,
    output logic              rom_req,
    output logic              rom_we,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [7:0]        rom_wdata,
    output logic              cap_en,
    output logic [7:0]        cap_byte,
    output logic              op_done
);

    localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

    typedef struct packed {
        seq_state_e     st;
        logic [IW-1:0]  idx;
        logic           wr;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic      running, skip, step;

    always_comb begin
        s_d     = s_q;
        running = (s_q.st == SEQ_RUN);
        skip    = running && s_q.wr && !lane_writable;
        rom_req = running && !skip;
        step    = skip || (rom_req && rom_ack);
        op_done = step && (s_q.idx == LAST);
        cap_en  = rom_req && rom_ack && !s_q.wr;

        if (!running && go) begin
            s_d.st  = SEQ_RUN;
            s_d.idx = '0;
            s_d.wr  = go_write;
        end
        if (step) begin
            if (s_q.idx == LAST) s_d.st  = SEQ_IDLE;
            else                 s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, idx: '0, wr: 1'b0};
        else        s_q <= s_d;
    end

    assign busy      = running;
    assign byte_idx  = s_q.idx;
    assign rom_we    = rom_req && s_q.wr;
    assign rom_addr  = rom_req ? lane_addr : '0;
    assign rom_wdata = (rom_req && s_q.wr) ? wr_data[8*s_q.idx +: 8] : 8'h00;
    assign cap_byte  = rom_rdata;

endmodule

// File: rtl/vpd_rom_ctrl.sv
module vpd_rom_ctrl #(
    parameter  int VPD_AW   = vpd_pkg::VPD_ADDR_W,
    parameter  int ROM_AW   = vpd_pkg::ROM_ADDR_W,
    parameter  int NBYTES   = vpd_pkg::XFER_BYTES,
    parameter  int CTL_W    = vpd_pkg::CTL_W,
    parameter  int FLAG_BIT = vpd_pkg::CTL_FLAG_BIT,
    parameter  int BASE     = vpd_pkg::ROM_BASE,
    parameter  int RW_LO    = vpd_pkg::WR_LO,
    parameter  int RW_SIZE  = vpd_pkg::WR_SIZE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_ctl_we,
    input  logic [CTL_W-1:0]      host_ctl_wdata,
    input  logic                  host_dat_we,
    input  logic [8*NBYTES-1:0]   host_dat_wdata,
    output logic [CTL_W-1:0]      host_ctl_rdata,
    output logic [8*NBYTES-1:0]   host_dat_rdata,
    output logic                  rom_req,
    output logic                  rom_we,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic [7:0]            rom_wdata,
    input  logic                  rom_ack,
    input  logic [7:0]            rom_rdata
);

    localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int DW = 8 * NBYTES;

    logic              go, go_write, busy, cap_en, op_done, lane_writable;
    logic [IW-1:0]     byte_idx;
    logic [7:0]        cap_byte;
    logic [VPD_AW-1:0] start_addr;
    logic [DW-1:0]     dat_q;
    logic [ROM_AW-1:0] lane_addr;

    vpd_host_regs #(
        .VPD_AW   (VPD_AW),
        .CTL_W    (CTL_W),
        .FLAG_BIT (FLAG_BIT),
        .NBYTES   (NBYTES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (host_ctl_we),
        .ctl_wdata  (host_ctl_wdata),
        .dat_we     (host_dat_we),
        .dat_wdata  (host_dat_wdata),
        .busy       (busy),
        .cap_en     (cap_en),
        .cap_idx    (byte_idx),
        .cap_byte   (cap_byte),
        .op_done    (op_done),
        .go         (go),
        .go_write   (go_write),
        .start_addr (start_addr),
        .dat_q      (dat_q),
        .ctl_rdata  (host_ctl_rdata)
    );

    vpd_addr_map #(
        .VPD_AW  (VPD_AW),
        .ROM_AW  (ROM_AW),
        .NBYTES  (NBYTES),
        .BASE    (BASE),
        .RW_LO   (RW_LO),
        .RW_SIZE (RW_SIZE)
    ) u_map (
        .start_addr    (start_addr),
        .lane_idx      (byte_idx),
        .lane_addr     (lane_addr),
        .lane_writable (lane_writable)
    );

    vpd_xfer_seq #(
        .ROM_AW (ROM_AW),
        .NBYTES (NBYTES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go),
        .go_write      (go_write),
        .wr_data       (dat_q),
        .lane_addr     (lane_addr),
        .lane_writable (lane_writable),
        .rom_ack       (rom_ack),
        .rom_rdata     (rom_rdata),
        .byte_idx      (byte_idx),
        .busy          (busy),
        .rom_req       (rom_req),
        .rom_we        (rom_we),
        .rom_addr      (rom_addr),
        .rom_wdata     (rom_wdata),
        .cap_en        (cap_en),
        .cap_byte      (cap_byte),
        .op_done       (op_done)
    );

    assign host_dat_rdata = dat_q;

endmodule

// File: rtl/vpd_rom_ctrl_chk.sv
module vpd_rom_ctrl_chk #(
    parameter int VPD_AW   = 9,
    parameter int ROM_AW   = 9,
    parameter int NBYTES   = 4,
    parameter int CTL_W    = 16,
    parameter int FLAG_BIT = 15,
    parameter int RW_LO    = 'h100
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_ctl_we,
    input logic                host_dat_we,
    input logic [CTL_W-1:0]    host_ctl_rdata,
    input logic [8*NBYTES-1:0] host_dat_rdata,
    input logic                rom_req,
    input logic                rom_we,
    input logic [ROM_AW-1:0]   rom_addr,
    input logic [7:0]          rom_wdata,
    input logic                rom_ack
);

    // Request and its payload are held until the acknowledge (R9)
    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && !rom_ack |=> rom_req && $stable(rom_addr) && $stable(rom_we) && $stable(rom_wdata));

    // No write request may reach the read-only area (R7)
    assert_no_protected_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && rom_we |-> {1'b0, rom_addr} >= (ROM_AW+1)'(RW_LO));

    // Flag shows "not done" during a read (R4)
    assert_read_flag_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && !rom_we |-> !host_ctl_rdata[FLAG_BIT]);

    // Flag stays set during a write (R6)
    assert_write_flag_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && rom_we |-> host_ctl_rdata[FLAG_BIT]);

    // Consecutive read bytes use ascending ROM addresses, wrapping (R3, R8)
    assert_ascending_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_req && rom_ack && !rom_we) ##1 rom_req |-> rom_addr == $past(rom_addr) + 1'b1);

    // Mid-transfer control writes leave the latched address alone (R10)
    assert_busy_ctl_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && host_ctl_we |=> $stable(host_ctl_rdata[VPD_AW-1:0]));

    // Mid-write data writes leave the data word alone (R10)
    assert_busy_dat_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && rom_we && host_dat_we |=> $stable(host_dat_rdata));

endmodule

bind vpd_rom_ctrl vpd_rom_ctrl_chk #(
    .VPD_AW   (VPD_AW),
    .ROM_AW   (ROM_AW),
    .NBYTES   (NBYTES),
    .CTL_W    (CTL_W),
    .FLAG_BIT (FLAG_BIT),
    .RW_LO    (RW_LO)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_ctl_we    (host_ctl_we),
    .host_dat_we    (host_dat_we),
    .host_ctl_rdata (host_ctl_rdata),
    .host_dat_rdata (host_dat_rdata),
    .rom_req        (rom_req),
    .rom_we         (rom_we),
    .rom_addr       (rom_addr),
    .rom_wdata      (rom_wdata),
    .rom_ack        (rom_ack)
);

// File: tb/vpd_rom_ctrl_bench.sv
`timescale 1ns/1ps
module vpd_rom_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ctl_we = 1'b0;
    logic [15:0] host_ctl_wdata = '0;
    logic        host_dat_we = 1'b0;
    logic [31:0] host_dat_wdata = '0;
    logic [15:0] host_ctl_rdata;
    logic [31:0] host_dat_rdata;
    logic        rom_req, rom_we;
    logic [8:0]  rom_addr;
    logic [7:0]  rom_wdata;
    logic        rom_ack = 1'b0;
    logic [7:0]  rom_rdata = '0;

    always #4 clk = ~clk;

    vpd_rom_ctrl u_vpd_rom_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_ctl_we(host_ctl_we), .host_ctl_wdata(host_ctl_wdata),
        .host_dat_we(host_dat_we), .host_dat_wdata(host_dat_wdata),
        .host_ctl_rdata(host_ctl_rdata), .host_dat_rdata(host_dat_rdata),
        .rom_req(rom_req), .rom_we(rom_we), .rom_addr(rom_addr),
        .rom_wdata(rom_wdata), .rom_ack(rom_ack), .rom_rdata(rom_rdata)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 37 + 11) ^ (i >> 4));
    endfunction

    // ---------------- reference model state (driven only by the clocked model) ----
    logic [7:0] mem [512];
    logic [8:0] m_addr = '0;
    logic       m_flag = 1'b0;
    logic       m_wr = 1'b0;
    logic [31:0] m_data = '0;
    logic       m_active = 1'b0;
    int         q_ra[$];
    bit         q_skip[$];
    int         q_idx[$];
    int         lat = 0;
    int         wait_n = 0;
    int         ack_total = 0;
    logic [8:0] hold_addr;
    logic       hold_we;
    logic [7:0] hold_wd;
    int         n_cmp_clk = 0, n_bad_clk = 0;
    int         n_cmp_dir = 0, n_bad_dir = 0;

    task automatic chk_clk(bit ok, string tag, longint act, longint exp);
        n_cmp_clk++;
        if (!ok) begin
            n_bad_clk++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit busy_prev;
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] = init_byte(i);
            // R1: outputs idle during reset
            chk_clk(host_ctl_rdata == 16'h0, "R1 ctl", host_ctl_rdata, 0);
            chk_clk(host_dat_rdata == 32'h0, "R1 dat", host_dat_rdata, 0);
            chk_clk(rom_req == 1'b0, "R1 req", rom_req, 0);
        end else begin
            // 1) events at the posedge just passed
            busy_prev = m_active;
            if (m_active && q_ra.size() > 0) begin
                if (q_skip[0] || rom_ack) begin
                    if (!q_skip[0] && !m_wr) m_data[8*q_idx[0] +: 8] = mem[q_ra[0]];
                    void'(q_ra.pop_front()); void'(q_skip.pop_front()); void'(q_idx.pop_front());
                    if (q_ra.size() == 0) begin
                        m_flag   = ~m_flag;
                        m_active = 1'b0;
                    end
                end
            end
            if (host_dat_we && !busy_prev) m_data = host_dat_wdata;
            if (host_ctl_we && !busy_prev) begin
                m_addr = host_ctl_wdata[8:0];
                m_flag = host_ctl_wdata[15];
                m_wr   = host_ctl_wdata[15];
                q_ra.delete(); q_skip.delete(); q_idx.delete();
                for (int k = 0; k < 4; k++) begin
                    int ra;
                    ra = (int'(host_ctl_wdata[8:0]) + 'h80 + k) % 512;
                    q_ra.push_back(ra);
                    q_skip.push_back(m_wr && (ra < 'h100));
                    q_idx.push_back(k);
                end
                m_active = 1'b1;
            end
            // 2) compare registers every clock
            chk_clk(host_ctl_rdata[8:0] == m_addr, "R2 addr field", host_ctl_rdata[8:0], m_addr);
            chk_clk(host_ctl_rdata[14:9] == 6'h0, "R2 reserved bits", host_ctl_rdata[14:9], 0);
            chk_clk(host_ctl_rdata[15] == m_flag, m_wr ? "R6 flag" : "R4 flag", host_ctl_rdata[15], m_flag);
            chk_clk(host_dat_rdata == m_data, m_wr ? "R10 data" : "R5 data", host_dat_rdata, m_data);
            // 3) ROM responder
            if (rom_ack) begin
                rom_ack = 1'b0;
                rom_rdata = 8'h00;
                wait_n = 0;
            end else if (rom_req) begin
                if (wait_n == 0) begin
                    hold_addr = rom_addr; hold_we = rom_we; hold_wd = rom_wdata;
                end else begin
                    chk_clk(rom_addr == hold_addr && rom_we == hold_we && rom_wdata == hold_wd,
                            "R9 held payload", rom_addr, hold_addr);
                end
                if (wait_n >= lat) begin
                    if (!(m_active && q_ra.size() > 0)) begin
                        chk_clk(1'b0, "R9 unexpected request", rom_addr, 0);
                    end else begin
                        chk_clk(!q_skip[0], "R7 request for protected byte", rom_addr, q_ra[0]);
                        chk_clk(int'(rom_addr) == q_ra[0], (q_ra[0] < 'h80) ? "R8 wrapped addr" : "R3 addr",
                                rom_addr, q_ra[0]);
                        chk_clk(rom_we == m_wr, "R6 direction", rom_we, m_wr);
                        if (m_wr)
                            chk_clk(rom_wdata == m_data[8*q_idx[0] +: 8], "R6 wdata",
                                    rom_wdata, m_data[8*q_idx[0] +: 8]);
                    end
                    if (rom_we) mem[rom_addr] = rom_wdata;
                    else        rom_rdata = mem[rom_addr];
                    rom_ack = 1'b1;
                    ack_total++;
                end else begin
                    wait_n++;
                end
            end else begin
                wait_n = 0;
            end
        end
    end

    // ---------------- stimulus and directed checks ----------------
    task automatic chk_dir(bit ok, string tag, longint act, longint exp);
        n_cmp_dir++;
        if (!ok) begin
            n_bad_dir++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    task automatic host_write(bit do_c, logic [15:0] c, bit do_d, logic [31:0] d);
        @(negedge clk); #1;
        host_ctl_we = do_c; host_ctl_wdata = c;
        host_dat_we = do_d; host_dat_wdata = d;
        @(negedge clk); #1;
        host_ctl_we = 1'b0; host_dat_we = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        do begin
            @(negedge clk); #2;
            guard++;
        end while (m_active && guard < 400);
    endtask

    task automatic do_read(logic [8:0] a);
        host_write(1'b1, {7'b0, a}, 1'b0, '0);
        wait_done();
    endtask

    task automatic do_write(logic [8:0] a, logic [31:0] d);
        host_write(1'b1, {1'b1, 6'b0, a}, 1'b1, d);
        wait_done();
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 n_cmp_clk + n_cmp_dir, n_bad_clk + n_bad_dir);
        $finish;
    endtask

    initial begin
        fork
            begin
                int acks_before;
                repeat (3) @(negedge clk);
                #2;
                chk_dir(host_ctl_rdata == 16'h0 && host_dat_rdata == 32'h0 && !rom_req,
                        "R1 reset state", host_ctl_rdata, 0);
                @(negedge clk); #1 rst_n = 1'b1;
                @(negedge clk); #2;
                chk_dir(host_ctl_rdata == 16'h0 && !rom_req, "R1 after release", host_ctl_rdata, 0);

                lat = 0;
                do_read(9'h000);
                chk_dir(host_ctl_rdata == 16'h8000, "R4 flag set after read", host_ctl_rdata, 16'h8000);
                chk_dir(host_dat_rdata[7:0] == init_byte('h080), "R5 byte0", host_dat_rdata[7:0], init_byte('h080));
                chk_dir(host_dat_rdata[31:24] == init_byte('h083), "R5 byte3", host_dat_rdata[31:24], init_byte('h083));

                lat = 2;
                do_read(9'h07E);
                chk_dir(host_dat_rdata[15:8] == init_byte('h0FF), "R3 unaligned", host_dat_rdata[15:8], init_byte('h0FF));
                do_read(9'h17D);
                chk_dir(host_dat_rdata[31:24] == init_byte('h000), "R8 wrap byte3", host_dat_rdata[31:24], init_byte('h000));
                chk_dir(host_dat_rdata[23:16] == init_byte('h1FF), "R8 last byte", host_dat_rdata[23:16], init_byte('h1FF));
                do_read(9'h1FF);
                chk_dir(host_dat_rdata[7:0] == init_byte('h07F), "R3 field wrap", host_dat_rdata[7:0], init_byte('h07F));

                lat = 1;
                do_write(9'h100, 32'h44332211);
                chk_dir(host_ctl_rdata == 16'h0100, "R6 flag cleared", host_ctl_rdata, 16'h0100);
                do_read(9'h100);
                chk_dir(host_dat_rdata == 32'h44332211, "R6 data landed", host_dat_rdata, 32'h44332211);

                do_write(9'h07E, 32'hA1B2C3D4);
                do_read(9'h07E);
                chk_dir(host_dat_rdata == {8'hA1, 8'hB2, init_byte('h0FF), init_byte('h0FE)},
                        "R7 leading skip", host_dat_rdata, {8'hA1, 8'hB2, init_byte('h0FF), init_byte('h0FE)});

                lat = 3;
                do_write(9'h17E, 32'h5566_7788);
                do_read(9'h17E);
                chk_dir(host_dat_rdata == {init_byte('h001), init_byte('h000), 8'h77, 8'h88},
                        "R7 trailing skip", host_dat_rdata, {init_byte('h001), init_byte('h000), 8'h77, 8'h88});

                acks_before = ack_total;
                do_write(9'h000, 32'hFFFF_FFFF);
                chk_dir(ack_total == acks_before, "R11 no requests", ack_total - acks_before, 0);
                chk_dir(host_ctl_rdata == 16'h0000, "R11 flag cleared", host_ctl_rdata, 0);

                // R10: writes while a read is in flight
                lat = 3;
                host_write(1'b1, 16'h0010, 1'b0, '0);
                host_write(1'b1, 16'h8120, 1'b1, 32'hDEADBEEF);
                wait_done();
                chk_dir(host_ctl_rdata == 16'h8010, "R10 ctl kept", host_ctl_rdata, 16'h8010);
                chk_dir(host_dat_rdata == {init_byte('h093), init_byte('h092), init_byte('h091), init_byte('h090)},
                        "R10 data kept", host_dat_rdata,
                        {init_byte('h093), init_byte('h092), init_byte('h091), init_byte('h090)});
                do_read(9'h120);
                chk_dir(host_dat_rdata[7:0] == init_byte('h1A0), "R10 rom untouched", host_dat_rdata[7:0], init_byte('h1A0));

                // R10: data write during a ROM write
                host_write(1'b1, 16'h8140, 1'b1, 32'h0BAD_F00D);
                host_write(1'b0, '0, 1'b1, 32'h1234_5678);
                wait_done();
                do_read(9'h140);
                chk_dir(host_dat_rdata == 32'h0BAD_F00D, "R10 write data kept", host_dat_rdata, 32'h0BAD_F00D);

                // sweep of starts and latencies
                for (int s = 0; s < 12; s++) begin
                    lat = s % 4;
                    do_read(9'((s * 53 + 5) % 512));
                    do_write(9'((s * 61 + 120) % 512), 32'(s * 32'h01010101 + 32'h10203040));
                end
                repeat (4) @(negedge clk);
            end
            begin
                repeat (150000) @(posedge clk);
                #1;
                chk_dir(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        report();
    end

endmodule